// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Configurator

This block turns a single 32-bit configuration word into the serial clock and the device-select lines of a SPI flash port. Software writes the word over a one-cycle write strobe. The word holds an enable bit, clock polarity and phase bits, a decoder-mode bit, a 4-bit select field and a 4-bit rate divisor. A read port returns the stored fields together with a read-only idle flag in the top bit.

A sequencer outside the block raises `xfer_active` for as long as a transfer runs. While the block is enabled and that input is high, the serial clock toggles at the reference rate divided by 2·(divisor+1), and the select field drives the select pins. In all other cycles the clock rests at the polarity level and every select pin sits high. The clock and select settings are frozen while the block is enabled, so the serial clock never glitches. In direct mode the select field must be an active-low one-cold pattern, and any other pattern is blocked. In decoder mode the field goes out as a raw code for an external decoder.

Top module: `spi_sclk_cs_cfg`

## Requirements
- R1: After reset the read port returns 0x8000_0000, `sclk` is 0 and `cs_n` is 4'b1111.
- R2: Read layout: bit 0 enable, bit 1 polarity, bit 2 phase, bit 9 decoder mode, bits 13:10 select field, bits 22:19 divisor, bit 31 idle flag (1 = no transfer). All other bits read 0. Writes to bit 31 are ignored.
- R3: While the stored enable bit is 1, a write changes only the enable bit. Polarity, phase, decoder mode, select and divisor keep their values.
- R4: A write made while the stored enable bit is 0 updates every field, including setting enable in the same write.
- R5: During a transfer every half period of `sclk` lasts divisor+1 reference cycles, covering divisors 0 through 15.
- R6: The divider restarts at every transfer start. The first `sclk` edge comes divisor+1 cycles after the first active cycle, even when a previous transfer stopped partway through a half period.
- R7: When no transfer is active, `sclk` equals the polarity bit and `cs_n` is all ones.
- R8: In direct mode, a select field with exactly one zero bit drives `cs_n` unchanged during a transfer.
- R9: In direct mode, a select field with zero or with two or more zero bits keeps `cs_n` at all ones during a transfer.
- R10: In decoder mode, any select field value drives `cs_n` unchanged during a transfer.
- R11: While the enable bit is 0, `xfer_active` has no effect: the idle flag stays 1, `sclk` stays at polarity and `cs_n` stays high.
- R12: The idle flag reads 0 from the cycle after `xfer_active` is sampled high with enable set, and reads 1 again in the cycle after `xfer_active` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration and idle flag |
| xfer_active | input | 1 | High while the sequencer runs a transfer |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low select lines or decoder code |

## Verification
The divider is run with divisors 0, 3 and 15 under both polarities. It is run through a stop and restart in the middle of a half period, so that an off-by-one in the count or a missing counter clear shows up as a wrong run length. Select patterns cover a valid one-cold value, a value with two zeros, the all-ones value and raw codes in decoder mode, which separates the pass, block and pass-through paths. Writes made while enabled, writes made while disabled, and transfer requests made while disabled separate the field lock from the enable path.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;
    localparam int REG_W    = 32;
    localparam int EN_BIT   = 0;
    localparam int POL_BIT  = 1;
    localparam int PHA_BIT  = 2;
    localparam int DEC_BIT  = 9;
    localparam int SEL_LSB  = 10;
    localparam int DIV_LSB  = 19;
    localparam int IDLE_BIT = 31;
    localparam int DEF_SEL_W = 4;
    localparam int DEF_DIV_W = 4;
endpackage

// File: rtl/spicfg_regs.sv
module spicfg_regs
    import spicfg_pkg::*;
#(
    parameter int SEL_W = DEF_SEL_W,
    parameter int DIV_W = DEF_DIV_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 busy,
    output logic                 en,
    output logic                 pol,
    output logic                 pha,
    output logic                 dec,
    output logic [SEL_W-1:0]     sel,
    output logic [DIV_W-1:0]     div,
    output logic [REG_W-1:0]     rdata
);
    typedef struct packed {
        logic             en;
        logic             pol;
        logic             pha;
        logic             dec;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.en = wdata[EN_BIT];
            if (!cfg_q.en) begin
                cfg_d.pol = wdata[POL_BIT];
                cfg_d.pha = wdata[PHA_BIT];
                cfg_d.dec = wdata[DEC_BIT];
                cfg_d.sel = wdata[SEL_LSB +: SEL_W];
                cfg_d.div = wdata[DIV_LSB +: DIV_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata                      = '0;
        rdata[EN_BIT]              = cfg_q.en;
        rdata[POL_BIT]             = cfg_q.pol;
        rdata[PHA_BIT]             = cfg_q.pha;
        rdata[DEC_BIT]             = cfg_q.dec;
        rdata[SEL_LSB +: SEL_W]    = cfg_q.sel;
        rdata[DIV_LSB +: DIV_W]    = cfg_q.div;
        rdata[IDLE_BIT]            = !busy;
    end

    assign en  = cfg_q.en;
    assign pol = cfg_q.pol;
    assign pha = cfg_q.pha;
    assign dec = cfg_q.dec;
    assign sel = cfg_q.sel;
    assign div = cfg_q.div;
endmodule

// File: rtl/spicfg_clkgen.sv
module spicfg_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             pol,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             active
);
    typedef struct packed {
        logic             active;
        logic             tog;
        logic [DIV_W-1:0] cnt;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d        = gen_q;
        gen_d.active = go;
        if (!go || !gen_q.active) begin
            gen_d.cnt = '0;
            gen_d.tog = 1'b0;
        end else if (gen_q.cnt == div) begin
            gen_d.cnt = '0;
            gen_d.tog = !gen_q.tog;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sclk   = pol ^ gen_q.tog;
    assign active = gen_q.active;
endmodule

// File: rtl/spicfg_csdrv.sv
module spicfg_csdrv #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             dec,
    input  logic [SEL_W-1:0] sel,
    output logic [SEL_W-1:0] cs_n
);
    localparam int CNT_W = $clog2(SEL_W + 1);

    logic [SEL_W-1:0] cs_d, cs_q;
    logic [CNT_W-1:0] zeros;

    always_comb begin
        zeros = '0;
        for (int i = 0; i < SEL_W; i++) begin
            zeros = zeros + CNT_W'(!sel[i]);
        end
    end

    always_comb begin
        cs_d = '1;
        if (go) begin
            if (dec)                  cs_d = sel;
            else if (zeros == CNT_W'(1)) cs_d = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '1;
        else        cs_q <= cs_d;
    end

    assign cs_n = cs_q;
endmodule

// File: rtl/spi_sclk_cs_cfg.sv
module spi_sclk_cs_cfg
    import spicfg_pkg::*;
#(
    parameter int SEL_W = DEF_SEL_W,
    parameter int DIV_W = DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             xfer_active,
    output logic             sclk,
    output logic [SEL_W-1:0] cs_n
);
    logic             en, pol, pha, dec, active, go;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
    logic             unused_pha;

    assign unused_pha = pha;
    assign go = en & xfer_active;

    spicfg_regs #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
        .busy(active), .en(en), .pol(pol), .pha(pha), .dec(dec),
        .sel(sel), .div(div), .rdata(cfg_rdata)
    );

    spicfg_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .go(go), .pol(pol), .div(div),
        .sclk(sclk), .active(active)
    );

    spicfg_csdrv #(.SEL_W(SEL_W)) u_csdrv (
        .clk(clk), .rst_n(rst_n), .go(go), .dec(dec), .sel(sel),
        .cs_n(cs_n)
    );
endmodule

// File: rtl/spicfg_chk.sv
module spicfg_chk
    import spicfg_pkg::*;
#(
    parameter int SEL_W = DEF_SEL_W,
    parameter int DIV_W = DEF_DIV_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      rd,
    input logic             sclk,
    input logic [SEL_W-1:0] cs_n
);
    // R7
    idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd[IDLE_BIT] |-> (sclk == rd[POL_BIT] && cs_n == '1));

    // R3
    locked_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd[EN_BIT] |=> $stable(rd[DIV_LSB+DIV_W-1:POL_BIT]));

    // R9
    one_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd[IDLE_BIT] && !rd[DEC_BIT]) |-> ($countones(~cs_n) <= 1));

    // R5
    fast_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd[IDLE_BIT] && !$past(rd[IDLE_BIT]) && rd[DIV_LSB +: DIV_W] == '0)
        |-> (sclk != $past(sclk)));

    // R2
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd[30:DIV_LSB+DIV_W] == '0 && rd[DEC_BIT-1:PHA_BIT+1] == '0));
endmodule

bind spi_sclk_cs_cfg spicfg_chk #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd(cfg_rdata), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/tb_spi_sclk_cs_cfg.sv
`timescale 1ns/1ps
module tb_spi_sclk_cs_cfg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        xfer_active = 1'b0;
    logic        sclk;
    logic [3:0]  cs_n;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    spi_sclk_cs_cfg dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .xfer_active(xfer_active), .sclk(sclk),
        .cs_n(cs_n)
    );

    function automatic logic [31:0] mk(bit en, bit pol, bit pha, bit dec,
                                       logic [3:0] sel, logic [3:0] div);
        logic [31:0] w = '0;
        w[0] = en; w[1] = pol; w[2] = pha; w[9] = dec;
        w[13:10] = sel; w[22:19] = div;
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic setup(bit pol, bit dec, logic [3:0] sel, logic [3:0] div);
        wr(mk(0, pol, 0, dec, sel, div));
        wr(mk(1, pol, 0, dec, sel, div));
    endtask

    task automatic start_xfer();
        xfer_active = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop_xfer();
        xfer_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_len(bit lvl, output int n);
        n = 0;
        while (sclk == lvl && n < 64) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 rdata", cfg_rdata, 32'h8000_0000);
        chk("R1 sclk", {31'd0, sclk}, 32'd0);
        chk("R1 cs_n", {28'd0, cs_n}, 32'hF);
    endtask

    task automatic t_layout();
        wr(32'hFFFF_FFFE);
        chk("R2 all fields", cfg_rdata, 32'h8078_3E06);
        wr(32'h0000_0000);
        chk("R2 cleared", cfg_rdata, 32'h8000_0000);
    endtask

    task automatic t_lock();
        wr(mk(1, 0, 0, 0, 4'hE, 4'd3));
        chk("R4 same-write enable", cfg_rdata, 32'h8018_3801);
        wr(mk(1, 1, 1, 1, 4'h7, 4'd5));
        chk("R3 locked", cfg_rdata, 32'h8018_3801);
        wr(32'h0);
        chk("R3 enable clears", cfg_rdata, 32'h8018_3800);
        wr(mk(0, 1, 0, 0, 4'hE, 4'd5));
        chk("R4 disabled write", cfg_rdata, 32'h8028_3802);
        wr(32'h0);
    endtask

    task automatic t_rate(bit pol, logic [3:0] div);
        int n;
        setup(pol, 0, 4'hE, div);
        start_xfer();
        chk("R12 idle low", {31'd0, cfg_rdata[31]}, 32'd0);
        run_len(pol, n);
        chk("R6 first half", n, div + 1);
        run_len(!pol, n);
        chk("R5 second half", n, div + 1);
        run_len(pol, n);
        chk("R5 third half", n, div + 1);
        stop_xfer();
        chk("R12 idle back", {31'd0, cfg_rdata[31]}, 32'd1);
        chk("R7 rest sclk", {31'd0, sclk}, {31'd0, pol});
        chk("R7 rest cs", {28'd0, cs_n}, 32'hF);
        wr(32'h0);
    endtask

    task automatic t_restart();
        int n;
        setup(0, 0, 4'hE, 4'd3);
        start_xfer();
        @(negedge clk);
        @(negedge clk);
        stop_xfer();
        start_xfer();
        run_len(0, n);
        chk("R6 restart half", n, 4);
        stop_xfer();
        wr(32'h0);
    endtask

    task automatic t_cs(bit dec, logic [3:0] sel, logic [3:0] exp, string req);
        setup(0, dec, sel, 4'd1);
        chk({req, " idle"}, {28'd0, cs_n}, 32'hF);
        start_xfer();
        chk(req, {28'd0, cs_n}, {28'd0, exp});
        stop_xfer();
        wr(32'h0);
    endtask

    task automatic t_disabled();
        wr(mk(0, 1, 0, 1, 4'h0, 4'd0));
        xfer_active = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 idle", {31'd0, cfg_rdata[31]}, 32'd1);
        chk("R11 sclk", {31'd0, sclk}, 32'd1);
        chk("R11 cs", {28'd0, cs_n}, 32'hF);
        stop_xfer();
        wr(32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_lock();
        t_rate(0, 4'd0);
        t_rate(0, 4'd3);
        t_rate(1, 4'd15);
        t_rate(1, 4'd2);
        t_restart();
        t_cs(0, 4'b0111, 4'b0111, "R8 device3");
        t_cs(0, 4'b1110, 4'b1110, "R8 device0");
        t_cs(0, 4'b1100, 4'b1111, "R9 two zeros");
        t_cs(0, 4'b1111, 4'b1111, "R9 no zero");
        t_cs(1, 4'b0101, 4'b0101, "R10 code5");
        t_cs(1, 4'b0000, 4'b0000, "R10 code0");
        t_disabled();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule